// File: doc/BRIEF.md
# Multi-Buffer Transfer Sequencer

This block keeps the transfer state of a pool of packet buffers that several data ports share. Software programs it with single 32-bit command words. Each word names a buffer, a port, an operation, a line step and a line range. A read or write command binds an idle buffer to a port. The block then offers that port a stream of line addresses, from the first line towards the last line, advancing by the step on each accepted beat.

The port answers each address beat with a ready, and may mark the beat as the end of its frame or as an error. When the transfer ends, the buffer holds a done or error flag until software clears it with a clear command. The block publishes a packed status word and, for each buffer, the last line actually transferred. An external packet classifier can tag any buffer as slow-path at any time. One interrupt line summarises all done and error flags.

Top module: `bufseq_top`

## Requirements
- R1: After reset the status word is 0x00FF0000, irq is 0, no port valid is high and every last-line field is 0. Status layout: bits 7:0 done per buffer, 15:8 error, 23:16 idle, 31:24 slow-path (bit index = buffer number within each byte).
- R2: A command word carries the buffer in bits 31:28, the port in 27:25, clear in 24, read in 23, write in 22, step in 21:18, last line in 17:9 and first line in 8:0. A read or write to an idle buffer clears its idle bit on the next cycle. The named port then shows pa_valid with pa_line = first line, pa_buf = the buffer index, and pa_write = 1 for write or 0 for read.
- R3: Each accepted beat (pa_valid and pa_ready high) advances the line by the step, with a step of 0 treated as 1. The beat whose line plus step exceeds the last line is the final beat, and it sets done. A beat accepted with pa_eof also ends the transfer with done.
- R4: A beat accepted with pa_err ends the transfer with the error bit set and the done bit clear, even when pa_eof is also high.
- R5: Every accepted beat stores its line number into that buffer's field of last_line (bits 9*b+8 : 9*b).
- R6: Done and error stay set until a clear command for that buffer. A clear also aborts an active transfer and clears slow-path, leaving the buffer idle.
- R7: A read or write naming a buffer that is not idle changes nothing.
- R8: A command naming buffer 8 or above, naming port 4 or above, or with more than one of clear/read/write set, changes nothing.
- R9: A pulse on slow_set[b] sets status bit 24+b on the next cycle and leaves the other bits alone. A set in the same cycle as a clear wins.
- R10: pa_valid and pa_line on a port hold steady while pa_ready is low. When several active buffers name the same port, the lowest-numbered one owns it, and the others wait.
- R11: irq is high exactly when any done or error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Packed command word |
| pa_valid | output | 4 | Per-port address beat valid |
| pa_ready | input | 4 | Per-port beat accept |
| pa_eof | input | 4 | Per-port end-of-frame with the beat |
| pa_err | input | 4 | Per-port error with the beat |
| pa_line | output | 36 | Per-port line address, 9 bits each |
| pa_buf | output | 12 | Per-port owning buffer index, 3 bits each |
| pa_write | output | 4 | Per-port direction, 1 = write into buffer |
| slow_set | input | 8 | Per-buffer slow-path tag pulse |
| status | output | 32 | Packed done/error/idle/slow-path word |
| last_line | output | 72 | Per-buffer last transferred line, 9 bits each |
| irq | output | 1 | OR of all done and error bits |

## Verification
The bench sweeps every buffer against every step value over varied ranges, and checks each address beat. An off-by-one end test would show up as an extra or a missing beat. A step-0 stall would hang the address, and the watchdog would catch it. Error beats also carry eof, so a design that let eof win would report done. The bench stalls ready on a port that two buffers contend for. A design that picked the wrong owner, or let the line move under back-pressure, would present the wrong buffer or a changed address. The bench also sends commands that must be ignored: a nil buffer, a nil port, several operations in one word, and a start on a busy buffer. A decoder that accepted any of these would change the status word or the stream.

// File: rtl/bufseq_pkg.sv
package bufseq_pkg;
  localparam int LINE_W = 9;
  localparam int STEP_W = 4;
  localparam int DEF_NBUF = 8;
  localparam int DEF_NPORT = 4;

  typedef struct packed {
    logic [3:0]        buf_id;
    logic [2:0]        port;
    logic              clr;
    logic              rd;
    logic              wr;
    logic [STEP_W-1:0] step;
    logic [LINE_W-1:0] last;
    logic [LINE_W-1:0] first;
  } cmd_t;
endpackage

// File: rtl/bufseq_decode.sv
module bufseq_decode #(
  parameter int NBUF = 8,
  parameter int NPORT = 4
) (
  input  logic            cmd_valid,
  input  logic [3:0]      buf_id,
  input  logic [2:0]      port,
  input  logic            clr,
  input  logic            rd,
  input  logic            wr,
  output logic [NBUF-1:0] start_o,
  output logic [NBUF-1:0] clear_o
);
  logic hit;
  // exactly one operation, real buffer, real port
  assign hit = cmd_valid && ($countones({clr, rd, wr}) == 1) &&
               (32'(buf_id) < NBUF) && (32'(port) < NPORT);

  for (genvar b = 0; b < NBUF; b++) begin : g_sel
    logic sel;
    assign sel = hit && (32'(buf_id) == b);
    assign start_o[b] = sel && (rd || wr);
    assign clear_o[b] = sel && clr;
  end
endmodule

// File: rtl/bufseq_slot.sv
module bufseq_slot
  import bufseq_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      clear_i,
  input  logic                      wr_i,
  input  logic [LINE_W-1:0]         first_i,
  input  logic [LINE_W-1:0]         last_i,
  input  logic [STEP_W-1:0]         step_i,
  input  logic [$clog2(NPORT)-1:0]  port_i,
  input  logic                      beat_i,
  input  logic                      eof_i,
  input  logic                      err_i,
  input  logic                      slow_set_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic                      slow_o,
  output logic [LINE_W-1:0]         line_o,
  output logic [$clog2(NPORT)-1:0]  port_o,
  output logic                      wr_o,
  output logic [LINE_W-1:0]         lastx_o
);
  logic [LINE_W-1:0] last_r;
  logic [STEP_W-1:0] step_r;
  logic [LINE_W:0]   step_eff, nxt;
  logic              final_beat, idle;

  assign idle       = !busy_o && !done_o && !err_o;
  assign step_eff   = (step_r == '0) ? (LINE_W+1)'(1) : (LINE_W+1)'(step_r);
  assign nxt        = {1'b0, line_o} + step_eff;
  assign final_beat = nxt > {1'b0, last_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      line_o  <= '0;
      last_r  <= '0;
      step_r  <= '0;
      port_o  <= '0;
      wr_o    <= 1'b0;
      lastx_o <= '0;
    end else if (clear_i) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else if (start_i && idle) begin
      busy_o <= 1'b1;
      line_o <= first_i;
      last_r <= last_i;
      step_r <= step_i;
      port_o <= port_i;
      wr_o   <= wr_i;
    end else if (busy_o && beat_i) begin
      lastx_o <= line_o;
      line_o  <= nxt[LINE_W-1:0];
      if (err_i) begin
        err_o  <= 1'b1;
        busy_o <= 1'b0;
      end else if (eof_i || final_beat) begin
        done_o <= 1'b1;
        busy_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          slow_o <= 1'b0;
    else if (slow_set_i) slow_o <= 1'b1;
    else if (clear_i)    slow_o <= 1'b0;
  end
endmodule

// File: rtl/bufseq_portsel.sv
module bufseq_portsel
  import bufseq_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int NPORT = 4
) (
  input  logic [NBUF-1:0]                 busy,
  input  logic [NBUF*$clog2(NPORT)-1:0]   port_of,
  input  logic [NBUF*LINE_W-1:0]          line_of,
  input  logic [NBUF-1:0]                 wr_of,
  output logic [NPORT-1:0]                pa_valid,
  output logic [NPORT*LINE_W-1:0]         pa_line,
  output logic [NPORT*$clog2(NBUF)-1:0]   pa_buf,
  output logic [NPORT-1:0]                pa_write,
  output logic [NBUF-1:0]                 grant
);
  localparam int PW = $clog2(NPORT);
  localparam int BW = $clog2(NBUF);

  logic [BW-1:0] owner [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      pa_valid[p] = 1'b0;
      owner[p]    = '0;
      // descending scan: lowest index wins
      for (int b = NBUF-1; b >= 0; b--) begin
        if (busy[b] && port_of[b*PW +: PW] == PW'(p)) begin
          pa_valid[p] = 1'b1;
          owner[p]    = BW'(b);
        end
      end
      pa_line[p*LINE_W +: LINE_W] = line_of[32'(owner[p])*LINE_W +: LINE_W];
      pa_buf[p*BW +: BW]          = owner[p];
      pa_write[p]                 = wr_of[owner[p]];
    end
  end

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      grant[b] = busy[b] && (owner[port_of[b*PW +: PW]] == BW'(b));
    end
  end
endmodule

// File: rtl/bufseq_top.sv
module bufseq_top
  import bufseq_pkg::*;
#(
  parameter int NBUF = DEF_NBUF,
  parameter int NPORT = DEF_NPORT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  input  logic [31:0]                     cmd_word,
  output logic [NPORT-1:0]                pa_valid,
  input  logic [NPORT-1:0]                pa_ready,
  input  logic [NPORT-1:0]                pa_eof,
  input  logic [NPORT-1:0]                pa_err,
  output logic [NPORT*LINE_W-1:0]         pa_line,
  output logic [NPORT*$clog2(NBUF)-1:0]   pa_buf,
  output logic [NPORT-1:0]                pa_write,
  input  logic [NBUF-1:0]                 slow_set,
  output logic [4*NBUF-1:0]               status,
  output logic [NBUF*LINE_W-1:0]          last_line,
  output logic                            irq
);
  localparam int PW = $clog2(NPORT);

  cmd_t cmd;
  assign cmd = cmd_t'(cmd_word);

  logic [NBUF-1:0]        start, clear, busy, done, err, slow, wr_of, grant, idle;
  logic [NBUF*PW-1:0]     port_of;
  logic [NBUF*LINE_W-1:0] line_of;

  bufseq_decode #(.NBUF(NBUF), .NPORT(NPORT)) u_dec (
    .cmd_valid(cmd_valid), .buf_id(cmd.buf_id), .port(cmd.port),
    .clr(cmd.clr), .rd(cmd.rd), .wr(cmd.wr),
    .start_o(start), .clear_o(clear)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    logic [PW-1:0] pp;
    assign pp = port_of[b*PW +: PW];
    bufseq_slot #(.NPORT(NPORT)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .start_i(start[b]), .clear_i(clear[b]), .wr_i(cmd.wr),
      .first_i(cmd.first), .last_i(cmd.last), .step_i(cmd.step),
      .port_i(cmd.port[PW-1:0]),
      .beat_i(grant[b] && pa_ready[pp]),
      .eof_i(pa_eof[pp]), .err_i(pa_err[pp]),
      .slow_set_i(slow_set[b]),
      .busy_o(busy[b]), .done_o(done[b]), .err_o(err[b]), .slow_o(slow[b]),
      .line_o(line_of[b*LINE_W +: LINE_W]), .port_o(port_of[b*PW +: PW]),
      .wr_o(wr_of[b]), .lastx_o(last_line[b*LINE_W +: LINE_W])
    );
    assign idle[b] = !busy[b] && !done[b] && !err[b];
  end

  bufseq_portsel #(.NBUF(NBUF), .NPORT(NPORT)) u_sel (
    .busy(busy), .port_of(port_of), .line_of(line_of), .wr_of(wr_of),
    .pa_valid(pa_valid), .pa_line(pa_line), .pa_buf(pa_buf),
    .pa_write(pa_write), .grant(grant)
  );

  assign status = {slow, idle, err, done};
  assign irq    = |{done, err};
endmodule

// File: rtl/bufseq_checker.sv
module bufseq_checker
  import bufseq_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int NPORT = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic [3:0]                    cmd_buf,
  input logic [NPORT-1:0]              pa_valid,
  input logic [NPORT-1:0]              pa_ready,
  input logic [NPORT*LINE_W-1:0]       pa_line,
  input logic [NPORT*$clog2(NBUF)-1:0] pa_buf,
  input logic [NBUF-1:0]               slow_set,
  input logic [4*NBUF-1:0]             status,
  input logic                          irq
);
  localparam int BW = $clog2(NBUF);

  // R6: done/error bits only fall on a command
  p_flags_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ((status[2*NBUF-1:0] & $past(status[2*NBUF-1:0])) == $past(status[2*NBUF-1:0])));

  // R8: nil buffer command with no beat and no tag leaves status alone
  p_nil_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && 32'(cmd_buf) >= NBUF && !(|(pa_valid & pa_ready)) && slow_set == '0)
      |=> $stable(status));

  // R9: a tag pulse lands in the slow-path field
  p_slow_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|slow_set) |=> ((status[4*NBUF-1:3*NBUF] & $past(slow_set)) == $past(slow_set)));

  // R11: interrupt only rises after an accepted beat
  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(pa_valid & pa_ready)));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // R10: stalled beat holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_valid[p] && !pa_ready[p] && !cmd_valid)
        |=> (pa_valid[p] && $stable(pa_line[p*LINE_W +: LINE_W])));
    // R2: an offered buffer is never idle
    p_owner_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pa_valid[p] |-> !status[2*NBUF + 32'(pa_buf[p*BW +: BW])]);
  end
endmodule

bind bufseq_top bufseq_checker #(.NBUF(NBUF), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_buf(cmd_word[31:28]),
  .pa_valid(pa_valid), .pa_ready(pa_ready), .pa_line(pa_line), .pa_buf(pa_buf),
  .slow_set(slow_set), .status(status), .irq(irq)
);

// File: tb/bufseq_top_bench.sv
module bufseq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [3:0]  pa_valid, pa_write;
  logic [3:0]  pa_ready = '0, pa_eof = '0, pa_err = '0;
  logic [35:0] pa_line;
  logic [11:0] pa_buf;
  logic [7:0]  slow_set = '0;
  logic [31:0] status;
  logic [71:0] last_line;
  logic        irq;

  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bufseq_top u_bufseq_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .pa_valid(pa_valid), .pa_ready(pa_ready), .pa_eof(pa_eof), .pa_err(pa_err),
    .pa_line(pa_line), .pa_buf(pa_buf), .pa_write(pa_write),
    .slow_set(slow_set), .status(status), .last_line(last_line), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int b, input int p, input bit c, input bit r,
                                     input bit w, input int s, input int l, input int f);
    return {4'(b), 3'(p), c, r, w, 4'(s), 9'(l), 9'(f)};
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // runs a started transfer to its natural end with ready held high
  task automatic run(input string req, input int b, input int p, input int f,
                     input int l, input int s, input bit w);
    int se = (s == 0) ? 1 : s;
    int e = f;
    int lastexp = f;
    while (1) begin
      chk({req, " valid"}, 32'(pa_valid[p]), 1);
      chk({req, " line"}, 32'(pa_line[p*9 +: 9]), 32'(e));
      chk({req, " buf"}, 32'(pa_buf[p*3 +: 3]), 32'(b));
      chk({req, " dir"}, 32'(pa_write[p]), 32'(w));
      pa_ready[p] = 1'b1;
      @(negedge clk);
      pa_ready[p] = 1'b0;
      lastexp = e;
      if (e + se > l) break;
      e = e + se;
    end
    chk({req, " done"}, 32'(status[b]), 1);
    chk({req, " err"}, 32'(status[8+b]), 0);
    chk("R5 lastline", 32'(last_line[b*9 +: 9]), 32'(lastexp));
    chk("R11 irq", 32'(irq), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 32'h00FF0000);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 valid", 32'(pa_valid), 0);
    chk("R1 lastline", 32'(|last_line), 0);

    // R2 R3 R5 sweep every buffer and every step value
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 16; s++) begin
        int p = (b + s) % 4;
        int f = (b * 61 + s * 29) % 512;
        int l = f + (s * 7 + b * 3) % 40;
        if (l > 511) l = 511;
        send(mk(b, p, 0, !s[0], s[0], s, l, f));
        chk("R2 idle cleared", 32'(status[16+b]), 0);
        run("R3 sweep", b, p, f, l, s, s[0]);
        send(mk(b, p, 1, 0, 0, 0, 0, 0));
        chk("R6 clear", status, 32'h00FF0000);
        chk("R11 irq low", 32'(irq), 0);
      end
    end

    // R4 error beat wins over eof
    send(mk(2, 1, 0, 0, 1, 2, 20, 10));
    pa_ready[1] = 1'b1;
    @(negedge clk);
    chk("R4 second line", 32'(pa_line[9 +: 9]), 12);
    pa_err[1] = 1'b1; pa_eof[1] = 1'b1;
    @(negedge clk);
    pa_ready[1] = 1'b0; pa_err[1] = 1'b0; pa_eof[1] = 1'b0;
    chk("R4 err bit", 32'(status[10]), 1);
    chk("R4 done bit", 32'(status[2]), 0);
    chk("R4 idle bit", 32'(status[18]), 0);
    chk("R4 stopped", 32'(pa_valid[1]), 0);
    chk("R5 err lastline", 32'(last_line[18 +: 9]), 12);
    repeat (5) @(negedge clk);
    chk("R6 err sticky", 32'(status[10]), 1);
    send(mk(2, 1, 0, 1, 0, 1, 30, 0));
    chk("R7 start on error buf", 32'(pa_valid[1]), 0);
    chk("R7 status kept", status, 32'h00FB0400);
    send(mk(2, 4, 1, 0, 0, 0, 0, 0));
    chk("R8 nil port clear", status, 32'h00FB0400);
    send(mk(2, 1, 1, 0, 0, 0, 0, 0));
    chk("R6 error cleared", status, 32'h00FF0000);

    // R3 early end of frame
    send(mk(3, 0, 0, 1, 0, 1, 100, 0));
    pa_ready[0] = 1'b1;
    repeat (2) @(negedge clk);
    pa_eof[0] = 1'b1;
    @(negedge clk);
    pa_ready[0] = 1'b0; pa_eof[0] = 1'b0;
    chk("R3 eof done", 32'(status[3]), 1);
    chk("R5 eof lastline", 32'(last_line[27 +: 9]), 2);
    send(mk(3, 0, 1, 0, 0, 0, 0, 0));

    // R7 restart on busy buffer ignored
    send(mk(4, 2, 0, 1, 0, 1, 9, 5));
    send(mk(4, 2, 0, 0, 1, 1, 250, 200));
    chk("R7 busy line", 32'(pa_line[18 +: 9]), 5);
    chk("R7 busy dir", 32'(pa_write[2]), 0);
    run("R7 finish", 4, 2, 5, 9, 1, 0);
    send(mk(4, 2, 1, 0, 0, 0, 0, 0));

    // R8 nil buffer, nil port, several operations
    send(mk(8, 0, 0, 1, 0, 1, 9, 0));
    chk("R8 nil buffer", status, 32'h00FF0000);
    chk("R8 nil buffer valid", 32'(pa_valid), 0);
    send(mk(5, 4, 0, 1, 0, 1, 9, 0));
    chk("R8 nil port", status, 32'h00FF0000);
    send(mk(5, 0, 0, 1, 1, 1, 9, 0));
    chk("R8 two ops", status, 32'h00FF0000);
    chk("R8 two ops valid", 32'(pa_valid), 0);

    // R10 contention and back-pressure
    send(mk(6, 3, 0, 0, 1, 1, 3, 0));
    send(mk(1, 3, 0, 1, 0, 1, 101, 100));
    for (int k = 0; k < 3; k++) begin
      chk("R10 owner", 32'(pa_buf[9 +: 3]), 1);
      chk("R10 hold line", 32'(pa_line[27 +: 9]), 100);
      @(negedge clk);
    end
    run("R10 low owner", 1, 3, 100, 101, 1, 0);
    run("R10 next owner", 6, 3, 0, 3, 1, 1);
    send(mk(1, 3, 1, 0, 0, 0, 0, 0));
    send(mk(6, 3, 1, 0, 0, 0, 0, 0));

    // R3 first beyond last: single beat
    send(mk(7, 2, 0, 1, 0, 3, 10, 300));
    run("R3 single", 7, 2, 300, 10, 3, 0);
    send(mk(7, 2, 1, 0, 0, 0, 0, 0));

    // R9 slow-path tag
    @(negedge clk);
    slow_set[5] = 1'b1;
    @(negedge clk);
    slow_set[5] = 1'b0;
    chk("R9 tag set", status, 32'h20FF0000);
    @(negedge clk);
    slow_set[5] = 1'b1;
    cmd_word = mk(5, 0, 1, 0, 0, 0, 0, 0); cmd_valid = 1'b1;
    @(negedge clk);
    slow_set[5] = 1'b0; cmd_valid = 1'b0;
    chk("R9 set wins", status, 32'h20FF0000);
    send(mk(5, 0, 1, 0, 0, 0, 0, 0));
    chk("R6 clear slow", status, 32'h00FF0000);
    chk("R11 final irq", 32'(irq), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule